// File: doc/BRIEF.md
# Emulation Memory Mapper with Wait States

The mapper sits between an emulated CPU's bus and the two memories an in-circuit emulator can hand a cycle to: the emulator's own RAM, or the memory on the target board. For every bus cycle it takes the address, an external bank number that extends that address, and a two-bit memory class. From these it decides which side serves the cycle and whether the cycle is allowed at all. It also decides how long the CPU has to wait before the cycle completes.

The map has two levels. A coarse table holds one entry per 4 KB block of the bank-extended space, kept separately for each of the four memory classes. Two relocatable windows hold one entry per byte, and a window entry that is marked as applying overrides the block entry for that byte. Every entry names one of a small set of range attribute slots. A slot carries a wait count of up to 250 cycles, an access-protect flag and a write-protect flag. A blocked cycle drives neither memory and raises a one-cycle violation pulse. It still returns ready, so the CPU never stalls forever.

The map is loaded through a simple write-only configuration port. The tables are plain dual-port memories: the configuration side writes them and the bus side reads them.

Top module: `emu_mem_mapper`

## Requirements
- R1: The coarse table is indexed by {class, bank, address[15:12]}. Its entry is bit0 = route (1 = emulation RAM) and bits 2:1 = attribute slot. The entry drives exactly one of sel_emu or sel_tgt. That select is held from the clock after the cycle starts through the clock in which ready is high.
- R2: Class codes 0 to 3 each select their own copy of the coarse table, so the same address can route differently by class.
- R3: The bank number forms the upper bits of the address used for both the block lookup and the window base match.
- R4: Each window has a 10-bit base that is compared with extended-address bits 19:10, and an enable bit. Its per-byte entry is bit0 = route, bits 2:1 = slot and bit3 = applies. A window entry that applies overrides the block entry. If both windows apply, window 0 wins. Disabling a window makes its entries stop applying.
- R5: Ready is high exactly N+1 clocks after the edge that samples cyc_start, where N is the matched slot's wait count, and only for one clock.
- R6: A wait count written above 250 is stored as 250.
- R7: If the slot is access-protected, sel_emu, sel_tgt and wr_en stay low, viol_acc pulses for one clock, and ready still arrives after N+1 clocks. viol_wr does not pulse.
- R8: If the slot is write-protected, a write gets wr_en low and a one-clock viol_wr pulse, while the select stays active. A read of the same slot gets no violation.
- R9: A cyc_start that arrives while a cycle is in flight is ignored.
- R10: After reset all outputs are low, every slot has wait 0 and no protection, and both windows are disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Target: 0 block table, 1 window 0, 2 window 1, 3 slot attribute, 4 window base |
| cfg_addr | input | 10 | Table index, slot number or window number |
| cfg_wdata | input | 16 | Entry data. Slot: [7:0] wait, [8] access-protect, [9] write-protect. Base: [9:0] base, [15] enable |
| cyc_start | input | 1 | One-clock pulse that starts a bus cycle |
| cpu_addr | input | 16 | CPU address |
| cpu_bank | input | 4 | External bank number |
| cpu_cls | input | 2 | Memory class |
| cpu_we | input | 1 | Cycle is a write |
| sel_emu | output | 1 | Cycle served by emulation RAM |
| sel_tgt | output | 1 | Cycle served by target memory |
| wr_en | output | 1 | Write permitted to the selected memory |
| viol_acc | output | 1 | Access-protection violation pulse |
| viol_wr | output | 1 | Write-protection violation pulse |
| ready | output | 1 | Cycle-complete pulse |

## Verification
A vector table sends reads and writes to one address under different classes and banks. This separates a class-indexed lookup from a bank-indexed one, and shows whether the bank bits reach the window base match. Three neighbouring bytes inside the overlapping windows are tried next: one where window 0 applies, one where only window 1 applies, and one where neither applies. Together they show window priority, fall-through and the block fallback. Slots with zero, small and saturated wait counts, and with each protection flag, are then driven with reads and writes, and the clock count to ready is measured in each case. Directed cases cover the reset defaults, a cyc_start that arrives during a 250-wait cycle, and a window being turned off.

// File: rtl/emm_pkg.sv
package emm_pkg;
  typedef enum logic [2:0] {
    CFG_BLK   = 3'd0,
    CFG_WIN0  = 3'd1,
    CFG_WIN1  = 3'd2,
    CFG_ATTR  = 3'd3,
    CFG_WBASE = 3'd4
  } cfg_sel_e;

  localparam int WAIT_W   = 8;
  localparam int MAX_WAIT = 250;
  localparam int CFG_DW   = 16;

  typedef struct packed {
    logic [WAIT_W-1:0] waits;
    logic              wprot;
    logic              aprot;
  } attr_t;
endpackage

// File: rtl/emm_map_ram.sv
module emm_map_ram #(
  parameter int DW = 4,
  parameter int AW = 10,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/emm_cfg_regs.sv
module emm_cfg_regs
  import emm_pkg::*;
#(
  parameter int NRANGE = 4,
  parameter int NWIN   = 2,
  parameter int BASE_W = 10,
  parameter int CFG_AW = 10,
  localparam int RID_W  = (NRANGE > 1) ? $clog2(NRANGE) : 1,
  localparam int WIDX_W = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        cfg_we,
  input  logic [2:0]                  cfg_sel,
  input  logic [CFG_AW-1:0]           cfg_addr,
  input  logic [CFG_DW-1:0]           cfg_wdata,
  output attr_t [NRANGE-1:0]          attrs,
  output logic  [NWIN-1:0][BASE_W-1:0] win_base,
  output logic  [NWIN-1:0]            win_en
);
  logic [WAIT_W-1:0] wait_in, wait_sat;
  logic              unused_bits;

  assign wait_in     = cfg_wdata[WAIT_W-1:0];
  assign wait_sat    = (wait_in > WAIT_W'(MAX_WAIT)) ? WAIT_W'(MAX_WAIT) : wait_in;
  assign unused_bits = ^{cfg_wdata, cfg_addr};

  for (genvar r = 0; r < NRANGE; r++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        attrs[r] <= '0;
      end else if (cfg_we && cfg_sel == CFG_ATTR &&
                   int'(cfg_addr[RID_W-1:0]) == r) begin
        attrs[r].waits <= wait_sat;
        attrs[r].aprot <= cfg_wdata[WAIT_W];
        attrs[r].wprot <= cfg_wdata[WAIT_W+1];
      end
    end
  end

  for (genvar w = 0; w < NWIN; w++) begin : g_wbase
    always_ff @(posedge clk) begin
      if (rst) begin
        win_base[w] <= '0;
        win_en[w]   <= 1'b0;
      end else if (cfg_we && cfg_sel == CFG_WBASE &&
                   int'(cfg_addr[WIDX_W-1:0]) == w) begin
        win_base[w] <= cfg_wdata[BASE_W-1:0];
        win_en[w]   <= cfg_wdata[CFG_DW-1];
      end
    end
  end
endmodule

// File: rtl/emm_wait_ctrl.sv
module emm_wait_ctrl #(
  parameter int WAIT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WAIT_W-1:0] wait_n,
  output logic              ready,
  output logic              act,
  output logic [WAIT_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ready <= 1'b0;
      act   <= 1'b0;
      cnt   <= '0;
    end else begin
      ready <= 1'b0;
      if (load) begin
        if (wait_n == '0) begin
          ready <= 1'b1;
        end else begin
          cnt <= wait_n;
          act <= 1'b1;
        end
      end else if (act) begin
        cnt <= cnt - WAIT_W'(1);
        if (cnt == WAIT_W'(1)) begin
          ready <= 1'b1;
          act   <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/emu_mem_mapper.sv
module emu_mem_mapper
  import emm_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BANK_W = 4,
  parameter int BLK_W  = 12,
  parameter int WIN_W  = 10,
  parameter int NWIN   = 2,
  parameter int NRANGE = 4,
  localparam int CLS_W  = 2,
  localparam int EXT_W  = BANK_W + ADDR_W,
  localparam int CIDX_W = CLS_W + EXT_W - BLK_W,
  localparam int BASE_W = EXT_W - WIN_W,
  localparam int RID_W  = (NRANGE > 1) ? $clog2(NRANGE) : 1,
  localparam int ENT_W  = 1 + RID_W,
  localparam int WENT_W = ENT_W + 1,
  localparam int CFG_AW = (CIDX_W > WIN_W) ? CIDX_W : WIN_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  input  logic              cyc_start,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [BANK_W-1:0] cpu_bank,
  input  logic [CLS_W-1:0]  cpu_cls,
  input  logic              cpu_we,
  output logic              sel_emu,
  output logic              sel_tgt,
  output logic              wr_en,
  output logic              viol_acc,
  output logic              viol_wr,
  output logic              ready
);
  logic [EXT_W-1:0]  ext;
  logic              accept, s1_v, s1_we;
  logic [BASE_W-1:0] s1_hi;
  logic              wait_act;
  logic [WAIT_W-1:0] wait_cnt;

  attr_t [NRANGE-1:0]           attrs;
  logic  [NWIN-1:0][BASE_W-1:0] win_base;
  logic  [NWIN-1:0]             win_en;

  logic [ENT_W-1:0]             c_q;
  logic [NWIN-1:0][WENT_W-1:0]  w_q;
  logic [ENT_W-1:0]             ent;
  logic                         route;
  attr_t                        at;

  assign ext    = {cpu_bank, cpu_addr};
  assign accept = cyc_start && !s1_v && !wait_act;

  // Stage 1: capture the cycle, start table reads
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v  <= 1'b0;
      s1_we <= 1'b0;
      s1_hi <= '0;
    end else begin
      s1_v <= accept;
      if (accept) begin
        s1_we <= cpu_we;
        s1_hi <= ext[EXT_W-1:WIN_W];
      end
    end
  end

  emm_cfg_regs #(
    .NRANGE (NRANGE),
    .NWIN   (NWIN),
    .BASE_W (BASE_W),
    .CFG_AW (CFG_AW)
  ) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .attrs     (attrs),
    .win_base  (win_base),
    .win_en    (win_en)
  );

  emm_map_ram #(.DW(ENT_W), .AW(CIDX_W)) u_blk (
    .clk   (clk),
    .we    (cfg_we && cfg_sel == CFG_BLK),
    .waddr (cfg_addr[CIDX_W-1:0]),
    .wdata (cfg_wdata[ENT_W-1:0]),
    .re    (accept),
    .raddr ({cpu_cls, ext[EXT_W-1:BLK_W]}),
    .rdata (c_q)
  );

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    emm_map_ram #(.DW(WENT_W), .AW(WIN_W)) u_win (
      .clk   (clk),
      .we    (cfg_we && cfg_sel == (3'(CFG_WIN0) + 3'(w))),
      .waddr (cfg_addr[WIN_W-1:0]),
      .wdata (cfg_wdata[WENT_W-1:0]),
      .re    (accept),
      .raddr (ext[WIN_W-1:0]),
      .rdata (w_q[w])
    );
  end

  // Stage 2: window priority over block entry, slot attributes
  always_comb begin
    logic hit;
    hit = 1'b0;
    ent = c_q;
    for (int w = 0; w < NWIN; w++) begin
      if (!hit && win_en[w] && s1_hi == win_base[w] && w_q[w][ENT_W]) begin
        hit = 1'b1;
        ent = w_q[w][ENT_W-1:0];
      end
    end
    route = ent[0];
    at    = attrs[ent[ENT_W-1:1]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_emu  <= 1'b0;
      sel_tgt  <= 1'b0;
      wr_en    <= 1'b0;
      viol_acc <= 1'b0;
      viol_wr  <= 1'b0;
    end else begin
      viol_acc <= 1'b0;
      viol_wr  <= 1'b0;
      if (s1_v) begin
        sel_emu  <= !at.aprot && route;
        sel_tgt  <= !at.aprot && !route;
        wr_en    <= s1_we && !at.aprot && !at.wprot;
        viol_acc <= at.aprot;
        viol_wr  <= s1_we && !at.aprot && at.wprot;
      end else if (ready) begin
        sel_emu <= 1'b0;
        sel_tgt <= 1'b0;
        wr_en   <= 1'b0;
      end
    end
  end

  emm_wait_ctrl #(.WAIT_W(WAIT_W)) u_wait (
    .clk    (clk),
    .rst    (rst),
    .load   (s1_v),
    .wait_n (at.waits),
    .ready  (ready),
    .act    (wait_act),
    .cnt    (wait_cnt)
  );
endmodule

// File: rtl/emm_mapper_chk.sv
module emm_mapper_chk
  import emm_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              sel_emu,
  input logic              sel_tgt,
  input logic              wr_en,
  input logic              viol_acc,
  input logic              viol_wr,
  input logic              ready,
  input logic              act,
  input logic [WAIT_W-1:0] cnt
);
  AST_SEL_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) $onehot0({sel_emu, sel_tgt})); // R1
  AST_READY_PULSE: assert property (@(posedge clk) disable iff (rst) ready |=> !ready); // R5
  AST_LAST_COUNT_READY: assert property (@(posedge clk) disable iff (rst) (act && cnt == WAIT_W'(1)) |=> ready); // R5
  AST_WAIT_CAPPED: assert property (@(posedge clk) disable iff (rst) act |-> (cnt <= WAIT_W'(MAX_WAIT))); // R6
  AST_PROT_BLOCKS: assert property (@(posedge clk) disable iff (rst) viol_acc |-> (!sel_emu && !sel_tgt && !wr_en && !viol_wr)); // R7
  AST_VIOL_PULSE: assert property (@(posedge clk) disable iff (rst) viol_acc |=> !viol_acc); // R7
  AST_WPROT_NO_WRITE: assert property (@(posedge clk) disable iff (rst) viol_wr |-> (!wr_en && (sel_emu || sel_tgt))); // R8
  AST_NO_READY_WHILE_COUNTING: assert property (@(posedge clk) disable iff (rst) act |-> !ready); // R9
endmodule

bind emu_mem_mapper emm_mapper_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .sel_emu  (sel_emu),
  .sel_tgt  (sel_tgt),
  .wr_en    (wr_en),
  .viol_acc (viol_acc),
  .viol_wr  (viol_wr),
  .ready    (ready),
  .act      (wait_act),
  .cnt      (wait_cnt)
);

// File: tb/emu_mem_mapper_test.sv
module emu_mem_mapper_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [9:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        cyc_start = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [3:0]  cpu_bank = '0;
  logic [1:0]  cpu_cls = '0;
  logic        cpu_we = 1'b0;
  logic        sel_emu, sel_tgt, wr_en, viol_acc, viol_wr, ready;

  int checks = 0;
  int fails  = 0;
  int wd     = 0;
  bit done   = 0;

  always #10 clk = ~clk; // 50 MHz

  emu_mem_mapper uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cyc_start(cyc_start), .cpu_addr(cpu_addr),
    .cpu_bank(cpu_bank), .cpu_cls(cpu_cls), .cpu_we(cpu_we), .sel_emu(sel_emu),
    .sel_tgt(sel_tgt), .wr_en(wr_en), .viol_acc(viol_acc), .viol_wr(viol_wr),
    .ready(ready)
  );

  typedef struct packed {
    logic [1:0]  cls;
    logic [3:0]  bank;
    logic [15:0] addr;
    logic        we;
    logic        ee, et, ew, eva, evw;
    logic [8:0]  n;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 4'd0, 16'h1800, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 9'd0,   4'd1}, // R1 read emu
    '{2'd0, 4'd0, 16'h1800, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 9'd0,   4'd1}, // R1 write emu
    '{2'd1, 4'd0, 16'h1800, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 9'd0,   4'd2}, // R2 class 1 -> target
    '{2'd0, 4'd1, 16'h1800, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 9'd3,   4'd3}, // R3 bank 1 slot 1 read
    '{2'd0, 4'd1, 16'h1800, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 9'd3,   4'd8}, // R8 write-protected
    '{2'd2, 4'd0, 16'h2004, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 9'd2,   4'd7}, // R7 read blocked
    '{2'd2, 4'd0, 16'h2004, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 9'd2,   4'd7}, // R7 write blocked
    '{2'd3, 4'd0, 16'h3000, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 9'd250, 4'd6}, // R6 saturated wait
    '{2'd0, 4'd0, 16'h1010, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 9'd3,   4'd4}, // R4 window 0 wins
    '{2'd0, 4'd0, 16'h1011, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 9'd0,   4'd4}, // R4 window 1 only
    '{2'd0, 4'd0, 16'h1012, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 9'd0,   4'd4}, // R4 no window applies
    '{2'd1, 4'd0, 16'h1010, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 9'd3,   4'd4}, // R4 window for any class
    '{2'd0, 4'd1, 16'h1010, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 9'd3,   4'd3}  // R3 other bank misses window
  };

  task automatic chk(input bit ok, input string req, input string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s", req, what);
    end
  endtask

  task automatic cfg(input logic [2:0] s, input logic [9:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run_cyc(input logic [1:0] cls, input logic [3:0] bank, input logic [15:0] addr,
                         input logic we, input logic ee, et, ew, eva, evw,
                         input int en, input string req);
    int  k;
    bit  got;
    @(negedge clk);
    cyc_start = 1'b1; cpu_cls = cls; cpu_bank = bank; cpu_addr = addr; cpu_we = we;
    @(posedge clk);
    @(negedge clk);
    cyc_start = 1'b0;
    k = 0; got = 0;
    while (!got && k < 400) begin
      @(posedge clk);
      k++;
      @(negedge clk);
      if (k == 1)
        chk({sel_emu, sel_tgt, wr_en, viol_acc, viol_wr} == {ee, et, ew, eva, evw}, req,
            $sformatf("outputs emu/tgt/wr/va/vw actual %b expected %b",
                      {sel_emu, sel_tgt, wr_en, viol_acc, viol_wr}, {ee, et, ew, eva, evw}));
      if (k == 2 && en >= 1)
        chk(!viol_acc && !viol_wr, req,
            $sformatf("violation pulse width actual va=%b vw=%b expected 0 0", viol_acc, viol_wr));
      if (ready) got = 1;
    end
    chk(got && k == en + 1, req,
        $sformatf("ready delay actual %0d expected %0d", k, en + 1));
    chk({sel_emu, sel_tgt, wr_en} == {ee, et, ew}, req,
        $sformatf("select held at ready actual %b expected %b", {sel_emu, sel_tgt, wr_en}, {ee, et, ew}));
    @(posedge clk);
    @(negedge clk);
    chk(!ready, "R5", $sformatf("ready after pulse actual %b expected 0", ready));
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R10: reset state
    chk({sel_emu, sel_tgt, wr_en, viol_acc, viol_wr, ready} == 6'b0, "R10",
        $sformatf("outputs after reset actual %b expected 000000",
                  {sel_emu, sel_tgt, wr_en, viol_acc, viol_wr, ready}));
    // R10: slot 3 defaults to wait 0, no protection
    cfg(3'd0, 10'h303, 16'h0006);
    run_cyc(2'd3, 4'd0, 16'h3000, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 0, "R10");
    // R10: windows disabled, so block entry used
    cfg(3'd0, 10'h011, 16'h0002);
    cfg(3'd0, 10'h001, 16'h0001);
    run_cyc(2'd0, 4'd0, 16'h1010, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 0, "R10");

    // program the rest of the map
    cfg(3'd0, 10'h101, 16'h0000);
    cfg(3'd0, 10'h202, 16'h0005);
    cfg(3'd3, 10'd0, 16'h0000);
    cfg(3'd3, 10'd1, 16'h0203);
    cfg(3'd3, 10'd2, 16'h0102);
    cfg(3'd3, 10'd3, 16'h00FF);
    cfg(3'd1, 10'h010, 16'h000A);
    cfg(3'd1, 10'h011, 16'h0000);
    cfg(3'd1, 10'h012, 16'h0000);
    cfg(3'd2, 10'h010, 16'h000D);
    cfg(3'd2, 10'h011, 16'h0008);
    cfg(3'd2, 10'h012, 16'h0000);
    cfg(3'd4, 10'd0, 16'h8004);
    cfg(3'd4, 10'd1, 16'h8004);

    for (int i = 0; i < NV; i++) begin
      run_cyc(VECS[i].cls, VECS[i].bank, VECS[i].addr, VECS[i].we, VECS[i].ee, VECS[i].et,
              VECS[i].ew, VECS[i].eva, VECS[i].evw, int'(VECS[i].n),
              $sformatf("R%0d vec%0d", VECS[i].req, i));
    end

    // R9: second start during a 250-wait cycle is ignored
    begin
      int  k;
      bit  got, saw_va;
      @(negedge clk);
      cyc_start = 1'b1; cpu_cls = 2'd3; cpu_bank = 4'd0; cpu_addr = 16'h3000; cpu_we = 1'b0;
      @(posedge clk);
      @(negedge clk);
      cyc_start = 1'b0;
      k = 0; got = 0; saw_va = 0;
      while (!got && k < 400) begin
        @(posedge clk);
        k++;
        @(negedge clk);
        cyc_start = 1'b0;
        if (k == 5) begin
          cyc_start = 1'b1; cpu_cls = 2'd2; cpu_addr = 16'h2004;
        end
        if (viol_acc) saw_va = 1;
        if (ready) got = 1;
      end
      chk(got && k == 251, "R9", $sformatf("ready delay actual %0d expected 251", k));
      chk(!saw_va && sel_tgt && !sel_emu, "R9",
          $sformatf("ignored start leaked actual va=%b tgt=%b expected 0 1", saw_va, sel_tgt));
      repeat (3) begin
        @(posedge clk);
        @(negedge clk);
        chk(!ready && !viol_acc, "R9",
            $sformatf("late cycle from ignored start actual rdy=%b va=%b expected 0 0", ready, viol_acc));
      end
    end

    // R4: disabling window 0 exposes window 1 (slot 2, access-protected)
    cfg(3'd4, 10'd0, 16'h0004);
    run_cyc(2'd0, 4'd0, 16'h1010, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2, "R4");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule